// File: doc/BRIEF.md
# Two-Wire Configuration Slave for a Clock Generator

This block is the serial control port of a clock generator. It watches a two-wire bus (clock line and open-drain data line), oversampled by the system clock, and lets a bus master program an external bank of configuration registers. The 7-bit device address is fixed, so the address byte is 0xD2 for a write and 0xD3 for a read.

A write has a fixed framing. After the address byte, two filler bytes (a command code and a byte count) must be sent. Both are acknowledged, and their contents play no part. Every later byte fills the next register, starting at index 0. A read has no pointer at all. Register 0 goes out straight after the address acknowledge, and the following registers go out in rising order for as long as the master acknowledges. The register bank sits outside the block and is reached through a one-cycle write strobe and a combinational read address and data pair.

Top module: `clkcfg_link`

## Requirements
- R1: While reset is held, and right after it is released, `sda_oe` is 0 and `reg_we` is 0.
- R2: A stop condition (SDA rising while SCL is high) ends a transfer. A start condition (SDA falling while SCL is high), including a repeated start in the middle of a transfer, restarts address reception and resets the register index to 0.
- R3: An address byte of 0xD2 or 0xD3 (address 7'b1101001, with the bit 0 of the byte being read=1) is acknowledged by driving SDA low during the ninth clock. Any other address is not acknowledged, and the slave then neither drives SDA nor writes a register until the next start.
- R4: In a write, the two bytes that follow the address are acknowledged, and they cause no register write.
- R5: Every later write byte is acknowledged and produces exactly one single-cycle `reg_we` pulse. `reg_waddr` is 0 for the first such byte and rises by one for each byte after it, and `reg_wdata` is the byte as received MSB first.
- R6: Write bytes aimed at index 6 (the read-only identifier) or at an index of `NUM_REGS` or more are acknowledged, but they raise no `reg_we`.
- R7: In a read, the slave sends the value of `reg_rdata` for index 0, then index 1 and so on, MSB first, moving to the next index after each master acknowledge (SDA low in the ninth clock).
- R8: When the master does not acknowledge (SDA high in the ninth clock), the slave releases SDA and drives it no more until the next start.
- R9: A read at an index of `NUM_REGS` or more returns 0xFF.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_waddr | output | AW | Register index for the write |
| reg_wdata | output | 8 | Register write data |
| reg_raddr | output | AW | Register index for the read |
| reg_rdata | input | 8 | Register contents at `reg_raddr` |

## Verification
The checks assume that each high and low phase of SCL lasts more than four system clocks. That gives the synchronizer and the one-cycle edge detector time to see every SCL edge before SDA moves. They also assume that the master changes SDA only while SCL is low, except when it makes a start or a stop. The stimulus keeps every bus phase at eight system clocks and changes SDA only at or after an SCL falling edge, so the check that `sda_oe` changes only while the raw SCL is low remains valid.

// File: rtl/clkcfg_link.sv
module clkcfg_link #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NUM_REGS = 7,
  parameter int RO_IDX = 6,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          reg_we,
  output logic [AW-1:0] reg_waddr,
  output logic [7:0]    reg_wdata,
  output logic [AW-1:0] reg_raddr,
  input  logic [7:0]    reg_rdata
);
  localparam logic [7:0] LAST = 8'(NUM_REGS);
  localparam logic [7:0] RO   = 8'(RO_IDX);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_APEND, S_ACK, S_TX, S_TXACK, S_TXNEXT} st_t;

  logic [2:0] scl_sy, sda_sy;
  st_t        st;
  logic [7:0] shreg, idx;
  logic [2:0] bitcnt;
  logic [1:0] bytecnt;
  logic       rw;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end

  wire scl_s = scl_sy[1];
  wire scl_p = scl_sy[2];
  wire sda_s = sda_sy[1];
  wire sda_p = sda_sy[2];
  wire rise  = scl_s & ~scl_p;
  wire fall  = ~scl_s & scl_p;
  wire start = scl_s & scl_p & sda_p & ~sda_s;
  wire stop  = scl_s & scl_p & ~sda_p & sda_s;

  wire [7:0] nb      = {shreg[6:0], sda_s};
  wire [7:0] idx_inc = (idx == 8'hFF) ? idx : idx + 8'd1;
  wire       in_rng  = idx < LAST;
  wire [7:0] rd_byte = in_rng ? reg_rdata : 8'hFF;

  assign reg_raddr = idx[AW-1:0];
  assign sda_oe    = (st == S_ACK) | ((st == S_TX) & ~shreg[7]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_IDLE;
      shreg     <= 8'hFF;
      idx       <= 8'd0;
      bitcnt    <= 3'd0;
      bytecnt   <= 2'd0;
      rw        <= 1'b0;
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_wdata <= 8'd0;
    end else begin
      reg_we <= 1'b0;
      if (start) begin
        st      <= S_RX;
        bitcnt  <= 3'd0;
        bytecnt <= 2'd0;
        idx     <= 8'd0;
      end else if (stop) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_RX: if (rise) begin
            shreg  <= nb;
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              bytecnt <= (bytecnt == 2'd3) ? bytecnt : bytecnt + 2'd1;
              if (bytecnt == 2'd0) begin
                rw <= nb[0];
                st <= (nb[7:1] == DEV_ADDR) ? S_APEND : S_IDLE;
              end else begin
                st <= S_APEND;
                if (bytecnt == 2'd3) begin
                  if (in_rng && idx != RO) begin
                    reg_we    <= 1'b1;
                    reg_waddr <= idx[AW-1:0];
                    reg_wdata <= nb;
                  end
                  idx <= idx_inc;
                end
              end
            end
          end
          S_APEND: if (fall) st <= S_ACK;
          S_ACK: if (fall) begin
            bitcnt <= 3'd0;
            if (rw) begin
              shreg <= rd_byte;
              st    <= S_TX;
            end else begin
              st <= S_RX;
            end
          end
          S_TX: if (fall) begin
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) st <= S_TXACK;
            else shreg <= {shreg[6:0], 1'b1};
          end
          S_TXACK: if (rise) begin
            if (!sda_s) begin
              idx <= idx_inc;
              st  <= S_TXNEXT;
            end else begin
              st <= S_IDLE;
            end
          end
          S_TXNEXT: if (fall) begin
            shreg  <= rd_byte;
            bitcnt <= 3'd0;
            st     <= S_TX;
          end
          default: ;
        endcase
      end
    end
endmodule

// File: rtl/clkcfg_link_chk.sv
module clkcfg_link_chk #(
  parameter int NUM_REGS = 7,
  parameter int RO_IDX = 6,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          reg_we,
  input logic [AW-1:0] reg_waddr
);
  // R5
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R6
  we_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (int'(reg_waddr) < NUM_REGS && int'(reg_waddr) != RO_IDX));

  // R10
  oe_lowscl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R5
  we_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !sda_oe);
endmodule

bind clkcfg_link clkcfg_link_chk #(.NUM_REGS(NUM_REGS), .RO_IDX(RO_IDX), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .reg_we(reg_we), .reg_waddr(reg_waddr)
);

// File: tb/clkcfg_link_tb_top.sv
`timescale 1ns/1ps
module clkcfg_link_tb_top;
  localparam int NR = 7;
  localparam int AW = $clog2(NR);

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_we;
  logic [AW-1:0] reg_waddr, reg_raddr;
  logic [7:0] reg_wdata, reg_rdata;
  wire sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  clkcfg_link dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
  );

  logic [7:0] bank [NR];
  logic [7:0] mdl  [NR];
  int we_cnt = 0, we_exp = 0, idx_m = 0;
  int n_chk = 0, n_fail = 0;
  bit cmp_en = 1'b0, oe_seen = 1'b0, prev_oe = 1'b0, done = 1'b0;

  assign reg_rdata = (int'(reg_raddr) < NR) ? bank[reg_raddr] : 8'h00;

  function automatic logic [7:0] dflt(int i);
    return (i == 0) ? 8'h00 : (i == 6) ? 8'h59 : 8'hFF;
  endfunction

  always @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) bank[i] <= dflt(i);
    end else if (reg_we) begin
      we_cnt <= we_cnt + 1;
      if (int'(reg_waddr) < NR) bank[reg_waddr] <= reg_wdata;
    end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the reference model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(!(sda_oe !== prev_oe && scl_m), "R10 sda_oe moved while SCL high", int'(sda_oe), int'(prev_oe));
      if (sda_oe) oe_seen = 1'b1;
      if (cmp_en) begin
        bit same = 1'b1;
        for (int i = 0; i < NR; i++) if (bank[i] !== mdl[i]) same = 1'b0;
        chk(same, "R5/R6 register bank vs model", 0, 0);
        chk(we_cnt == we_exp, "R4/R6 write strobe count", we_cnt, we_exp);
      end
    end
    prev_oe = sda_oe;
  end

  task automatic hw(int n = 8);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(); scl_m = 1'b1; hw(); sda_m = 1'b0; hw(); scl_m = 1'b0; hw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw(); scl_m = 1'b1; hw(); sda_m = 1'b1; hw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw(); scl_m = 1'b1; hw(); scl_m = 1'b0;
    end
    sda_m = 1'b1; hw(); scl_m = 1'b1; hw(4); a = sda_line; hw(4); scl_m = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      hw(); scl_m = 1'b1; hw(4); b[i] = sda_line; hw(4); scl_m = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1; hw(); scl_m = 1'b1; hw(); scl_m = 1'b0; sda_m = 1'b1;
  endtask

  task automatic wr_head(input string tag);
    logic a;
    bus_start();
    idx_m = 0;
    send_byte(8'hD2, a); chk(a == 1'b0, {"R3 write address ack ", tag}, int'(a), 0);
    send_byte(8'h5A, a); chk(a == 1'b0, "R4 command byte ack", int'(a), 0);
    send_byte(8'h07, a); chk(a == 1'b0, "R4 count byte ack", int'(a), 0);
    chk(we_cnt == we_exp, "R4 filler bytes write nothing", we_cnt, we_exp);
  endtask

  task automatic wr_data(input logic [7:0] b);
    logic a;
    cmp_en = 1'b0;
    send_byte(b, a);
    chk(a == 1'b0, "R5/R6 data byte ack", int'(a), 0);
    if (idx_m < NR && idx_m != 6) begin
      mdl[idx_m] = b;
      we_exp++;
    end
    idx_m++;
    cmp_en = 1'b1;
  endtask

  task automatic rd_seq(input int n);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, a); chk(a == 1'b0, "R3 read address ack", int'(a), 0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = (i < NR) ? mdl[i] : 8'hFF;
      recv_byte(b, i != n - 1);
      chk(b == e, (i < NR) ? "R7 read byte" : "R9 read past end", int'(b), int'(e));
    end
    oe_seen = 1'b0;
    for (int i = 0; i < 9; i++) begin
      hw(); scl_m = 1'b1; hw(); scl_m = 1'b0;
    end
    chk(!oe_seen, "R8 released after NACK", int'(oe_seen), 0);
    bus_stop();
  endtask

  initial begin
    logic a;
    for (int i = 0; i < NR; i++) mdl[i] = dflt(i);
    hw(5);
    chk(sda_oe == 1'b0 && reg_we == 1'b0, "R1 outputs during reset", int'({sda_oe, reg_we}), 0);
    rst_n = 1'b1;
    hw(4);
    chk(sda_oe == 1'b0 && reg_we == 1'b0, "R1 outputs after reset", int'({sda_oe, reg_we}), 0);
    cmp_en = 1'b1;

    wr_head("A");
    wr_data(8'h11); wr_data(8'h22); wr_data(8'h33);
    bus_stop();
    rd_seq(4);

    bus_start();
    oe_seen = 1'b0;
    send_byte(8'hA0, a); chk(a == 1'b1, "R3 foreign address not acked", int'(a), 1);
    send_byte(8'h5A, a); chk(a == 1'b1, "R3 ignored after miss", int'(a), 1);
    send_byte(8'h00, a); chk(a == 1'b1, "R3 ignored after miss", int'(a), 1);
    send_byte(8'hC3, a);
    chk(!oe_seen, "R3 no drive after miss", int'(oe_seen), 0);
    chk(we_cnt == we_exp, "R3 no write after miss", we_cnt, we_exp);
    bus_stop();

    wr_head("B");
    for (int i = 0; i < 9; i++) wr_data(8'(8'hA1 + 8'(i * 17)));
    bus_stop();
    chk(bank[6] == 8'h59, "R6 read-only index kept", int'(bank[6]), 'h59);
    rd_seq(10);

    wr_head("C");
    wr_data(8'h44);
    bus_start();
    idx_m = 0;
    send_byte(8'hD2, a); chk(a == 1'b0, "R2 repeated start address ack", int'(a), 0);
    send_byte(8'h01, a); send_byte(8'h02, a);
    wr_data(8'h55);
    chk(bank[0] == 8'h55, "R2 index reset by repeated start", int'(bank[0]), 'h55);
    bus_stop();

    bus_start();
    send_byte(8'hD2, a); send_byte(8'h09, a);
    bus_stop();
    wr_head("D");
    wr_data(8'h66);
    bus_stop();
    chk(bank[0] == 8'h66, "R2 stop mid-frame then fresh write", int'(bank[0]), 'h66);
    rd_seq(2);

    hw(10);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4ns * 150000);
    done = 1'b1;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule